// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns one raw PWM waveform into a complementary pair of gate drives, A and B, for the two switches of a half bridge. A copies the input but has its rising edge held back by a programmable number of clock cycles. B is the inverse of the input, with its rising edge (the input's falling edge) held back by a second, independent count. While either delay runs, both drives are low. This gap is the transition interval that lets the bridge node swing before the next switch turns on.

Both delay counts may be rewritten while the PWM is running. Each edge latches its count when its countdown begins, so a write only affects edges that come later. Clearing the enable bypasses both delays: A follows the input and B follows its inverse. All paths have the same single-register latency.

Top module: `deadband_gen`

## Requirements
- R1: While `rst_n` is low, both `out_a` and `out_b` are low.
- R2: With `en` high, a rising edge of `pwm_in` first sampled at clock edge k drives `out_a` high after edge k+`rise_dly`. `out_a` falls after the first edge that samples `pwm_in` low.
- R3: With `en` high, a falling edge of `pwm_in` first sampled at edge k drives `out_b` high after edge k+`fall_dly`. `out_b` falls after the first edge that samples `pwm_in` high.
- R4: A delay value of 0 passes the edge with only the one-register latency, the same as a falling edge.
- R5: A high (low) input pulse of `rise_dly` (`fall_dly`) samples or fewer never raises `out_a` (`out_b`).
- R6: `out_a` and `out_b` are never high in the same cycle.
- R7: A delay value is captured in the cycle its edge is first sampled. A later change of `rise_dly` or `fall_dly` does not alter a countdown already running.
- R8: With `en` low, after each edge `out_a` equals the sampled `pwm_in` and `out_b` its inverse.
- R9: The two delay counts act independently, so unequal values give unequal gaps before A and before B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | 1: apply delays; 0: bypass |
| pwm_in | input | 1 | Raw PWM input, synchronous to clk |
| rise_dly | input | DLY_W | Delay in cycles before A rises |
| fall_dly | input | DLY_W | Delay in cycles before B rises |
| out_a | output | 1 | High-side gate drive |
| out_b | output | 1 | Low-side gate drive |

## Verification
The assertions assume that `pwm_in`, `en` and both delay counts are synchronous to `clk` and hold known values from the release of reset. The countdown and edge properties would otherwise compare values against unknowns. The bench changes every input only on the falling clock edge and drives defined values throughout reset. It sweeps the delay pair across small values against square waves whose high and low widths fall below, at and above the delays. It also rewrites a delay mid-countdown and runs one maximum-length delay.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    // Phase of one edge-delay path
    typedef enum logic [1:0] {
        PH_LOW  = 2'd0,
        PH_WAIT = 2'd1,
        PH_HIGH = 2'd2
    } dly_phase_e;

    // Registered state of the output stage
    typedef struct packed {
        logic live;
        logic en;
        logic x;
    } stage_t;

endpackage

// File: rtl/dbg_edge_delay.sv
// Holds back the rising edge of one signal by a latched count; falling
// edges pass after the single pipeline register.
module dbg_edge_delay #(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [DLY_W-1:0] dly,
    output logic             sig_out
);
    import dbg_pkg::*;

    typedef struct packed {
        dly_phase_e       ph;
        logic [DLY_W-1:0] cnt;
    } ed_state_t;

    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    ed_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_LOW: begin
                if (sig_in) begin
                    if (dly == '0) begin
                        st_d.ph  = PH_HIGH;
                        st_d.cnt = '0;
                    end else begin
                        st_d.ph  = PH_WAIT;
                        st_d.cnt = dly;
                    end
                end
            end
            PH_WAIT: begin
                if (!sig_in) begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                end else if (st_q.cnt == ONE) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_HIGH: begin
                if (!sig_in) begin
                    st_d.ph = PH_LOW;
                end
            end
            default: begin
                st_d.ph  = PH_LOW;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_LOW;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_out = (st_q.ph == PH_HIGH);

    // A low input always ends the path at the next edge
    p_drop_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_in |=> (st_q.ph == PH_LOW));

    // Zero delay reaches high on the very next edge
    p_zero_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_LOW && sig_in && dly == '0) |=> (st_q.ph == PH_HIGH));

    // A running countdown steps by one regardless of the dly input
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_WAIT && sig_in && st_q.cnt > ONE)
            |=> (st_q.ph == PH_WAIT && st_q.cnt == $past(st_q.cnt) - ONE));

    // Waiting implies a nonzero count remains
    p_wait_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_WAIT) |-> (st_q.cnt != '0));

endmodule

// File: rtl/dbg_out_stage.sv
// Registers the bypass path and enable, then selects delayed or bypass drive.
module dbg_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic x,
    input  logic a_dly,
    input  logic b_dly,
    output logic a,
    output logic b
);
    import dbg_pkg::*;

    stage_t sg_d, sg_q;

    always_comb begin
        sg_d      = sg_q;
        sg_d.live = 1'b1;
        sg_d.en   = en;
        sg_d.x    = x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sg_q <= '0;
        end else begin
            sg_q <= sg_d;
        end
    end

    always_comb begin
        a = 1'b0;
        b = 1'b0;
        if (sg_q.live) begin
            if (sg_q.en) begin
                a = a_dly;
                b = b_dly;
            end else begin
                a = sg_q.x;
                b = !sg_q.x;
            end
        end
    end

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen #(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pwm_in,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             out_a,
    output logic             out_b
);
    localparam int N_PATH = 2;

    logic             path_src [N_PATH];
    logic [DLY_W-1:0] path_dly [N_PATH];
    logic             path_out [N_PATH];

    // Path 0 delays the input's rise (drive A); path 1 delays its fall (drive B)
    assign path_src[0] = pwm_in;
    assign path_src[1] = !pwm_in;
    assign path_dly[0] = rise_dly;
    assign path_dly[1] = fall_dly;

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        dbg_edge_delay #(.DLY_W(DLY_W)) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (path_src[g]),
            .dly    (path_dly[g]),
            .sig_out(path_out[g])
        );
    end

    dbg_out_stage u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .x    (pwm_in),
        .a_dly(path_out[0]),
        .b_dly(path_out[1]),
        .a    (out_a),
        .b    (out_b)
    );

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_a == $past(pwm_in) && out_b == !$past(pwm_in)));

    p_a_needs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pwm_in) |=> !out_a);

    p_b_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pwm_in) |=> !out_b);

endmodule

// File: tb/deadband_gen_test.sv
module deadband_gen_test;
    localparam int DLY_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             pwm_in = 1'b0;
    logic [DLY_W-1:0] rise_dly = '0;
    logic [DLY_W-1:0] fall_dly = '0;
    logic             out_a, out_b;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    int run_hi = 0;
    int run_lo = 0;
    int dr_l = 0;
    int df_l = 0;
    logic en_s = 1'b0;
    logic x_s = 1'b0;

    always #5 clk = !clk;

    deadband_gen #(.DLY_W(DLY_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm_in),
        .rise_dly(rise_dly), .fall_dly(fall_dly),
        .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input string tag, input string what,
                       input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: model updated at the edge, outputs compared at the falling edge
    task automatic tick(input string ta, input string tb);
        logic ea, eb;
        @(posedge clk);
        en_s = en;
        x_s  = pwm_in;
        if (pwm_in) begin
            if (run_hi == 0) dr_l = int'(rise_dly);
            run_hi++;
            run_lo = 0;
        end else begin
            if (run_lo == 0) df_l = int'(fall_dly);
            run_lo++;
            run_hi = 0;
        end
        @(negedge clk);
        ea = en_s ? (run_hi >= dr_l + 1) : x_s;
        eb = en_s ? (run_lo >= df_l + 1) : !x_s;
        chk(ta, "out_a", out_a, ea);
        chk(tb, "out_b", out_b, eb);
        chk("R6", "overlap", out_a & out_b, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] lfsr;
        string ta, tb;
        // R1: reset state
        pwm_in = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R1", "out_a", out_a, 1'b0);
            chk("R1", "out_b", out_b, 1'b0);
        end
        pwm_in = 1'b0;
        rst_n  = 1'b1;

        // R8: bypass with a pseudo-random input
        en   = 1'b0;
        lfsr = 8'hA5;
        rise_dly = 10'd3;
        fall_dly = 10'd2;
        for (int i = 0; i < 48; i++) begin
            pwm_in = lfsr[0];
            lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick("R8", "R8");
        end

        // R2..R5: sweep delays against square waves of many widths
        en = 1'b1;
        for (int dr = 0; dr < 5; dr++) begin
            for (int df = 0; df < 5; df++) begin
                rise_dly = DLY_W'(dr);
                fall_dly = DLY_W'(df);
                for (int wh = 1; wh <= 6; wh++) begin
                    for (int wl = 1; wl <= 6; wl++) begin
                        ta = (dr == 0) ? "R4" : ((wh <= dr) ? "R5" : "R2");
                        tb = (df == 0) ? "R4" : ((wl <= df) ? "R5" : "R3");
                        pwm_in = 1'b1;
                        for (int k = 0; k < wh; k++) tick(ta, tb);
                        pwm_in = 1'b0;
                        for (int k = 0; k < wl; k++) tick(ta, tb);
                    end
                end
            end
        end

        // R9: unequal delays on a long square wave
        rise_dly = 10'd7;
        fall_dly = 10'd3;
        for (int p = 0; p < 6; p++) begin
            pwm_in = 1'b1;
            for (int k = 0; k < 12; k++) tick("R9", "R9");
            pwm_in = 1'b0;
            for (int k = 0; k < 12; k++) tick("R9", "R9");
        end

        // R7: rewrite delays in the middle of running countdowns
        rise_dly = 10'd10;
        fall_dly = 10'd9;
        pwm_in   = 1'b1;
        for (int k = 0; k < 3; k++) tick("R7", "R7");
        rise_dly = 10'd1;
        for (int k = 0; k < 15; k++) tick("R7", "R7");
        pwm_in = 1'b0;
        for (int k = 0; k < 2; k++) tick("R7", "R7");
        fall_dly = 10'd0;
        for (int k = 0; k < 14; k++) tick("R7", "R7");
        pwm_in = 1'b1;
        for (int k = 0; k < 4; k++) tick("R7", "R7");

        // R2: maximum delay count
        rise_dly = '1;
        fall_dly = 10'd1;
        pwm_in   = 1'b0;
        for (int k = 0; k < 4; k++) tick("R2", "R3");
        pwm_in = 1'b1;
        for (int k = 0; k < 1030; k++) tick("R2", "R3");
        pwm_in = 1'b0;
        for (int k = 0; k < 4; k++) tick("R2", "R3");

        // R8: drop enable while running, then back
        en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            pwm_in = k[1];
            tick("R8", "R8");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule